// File: doc/BRIEF.md
# Pipelined Digit-Grid Tree Multiplier

This block multiplies two unsigned operands of `W` bits and returns their full `2W`-bit product. Each operand is cut into `D`-bit digits. Every pairing of a multiplicand digit with a multiplier digit is sent to a tiny lookup-table multiplier. Each small product is moved to the weight of its digit pair. A binary tree of adders then sums the weighted products. A register follows every lookup node and every adder node, so the longest path between two registers passes through one node.

A new operand pair is taken on every clock, and each product comes out a fixed number of cycles later. An input valid bit moves through a shift register of the same depth as the data, so the output valid marks exactly the cycles that carry a real product. Loops that feed a product back to their own inputs must allow for this fixed latency.

Top module: `mtree_mul`

## Requirements
- R1: With default parameters (`W`=8, `D`=2), `out_p` is the exact unsigned product `in_a*in_b`, 16 bits wide with no truncation. This covers zero operands and all-ones operands.
- R2: The block has one lookup-table digit multiplier for every digit pair, (W/D)^2 in total. Each one returns the exact product of its two `D`-bit digits for all 2^(2D) digit combinations.
- R3: The product of multiplicand digit i (bits i*D upward) and multiplier digit j is weighted by a left shift of D*(i+j). An operand pair with only digit i set in `in_a` and only digit j set in `in_b` yields `(3<<2i)*(3<<2j)`.
- R4: The registered adder tree uses 2W-bit adders at every level, so carries from the largest digit products are never lost.
- R5: Operands captured at a rising edge appear on `out_p`/`out_vld` right after the edge that is LAT-1 edges later, where LAT = 1 + 2*log2(W/D). With the defaults, LAT = 5.
- R6: Operand pairs may be presented on consecutive cycles without gaps. Every one of them produces its own product, in order.
- R7: `out_vld` is 1 only in a cycle where `out_p` holds the product of a pair that was applied with `in_vld`=1. Cycles where `in_vld`=0 come out with `out_vld`=0.
- R8: `rst` is synchronous and active-high. An edge with `rst`=1 clears the valid bit of every pipeline stage, so pairs that are in flight never show `out_vld`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Marks `in_a`/`in_b` as a real operand pair |
| in_a | input | W | Unsigned multiplicand |
| in_b | input | W | Unsigned multiplier |
| out_vld | output | 1 | Marks `out_p` as a real product |
| out_p | output | 2W | Unsigned product |

## Verification
The hardest case to reach from the ports is a reset that arrives while several operand pairs are partway through the tree. Only a valid bit that reset fails to clear, or a valid bit that drifts out of step with its data, would show the fault. The stimulus therefore fills the pipeline with back-to-back valid pairs and raises reset for a single edge. It then resumes at once. The bench's model drops exactly the pairs that were captured within the last LAT edges. Pairs that each excite a single digit position, and every digit-value combination, make sure each lookup node and each shift weight can be seen at the output.

// File: rtl/mtree_pkg.sv
package mtree_pkg;

    // Shift-add product of two small unsigned values; used to fill digit tables.
    function automatic int unsigned small_mul(input int unsigned x, input int unsigned y);
        int unsigned acc;
        acc = 0;
        for (int k = 0; k < 16; k++) begin
            if (y[k]) acc = acc + (x << k);
        end
        return acc;
    endfunction

endpackage

// File: rtl/digit_lut.sv
module digit_lut #(
    parameter int D = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [D-1:0]   a_dig,
    input  logic [D-1:0]   b_dig,
    output logic [2*D-1:0] prod_q
);
    import mtree_pkg::*;

    localparam int PW2  = 2 * D;
    localparam int NENT = 1 << PW2;

    logic [PW2-1:0] tbl [NENT];
    logic [PW2-1:0] prod_d;

    // Table indexed by {a_dig, b_dig}
    always_comb begin
        for (int k = 0; k < NENT; k++) begin
            tbl[k] = PW2'(small_mul(k >> D, k % (1 << D)));
        end
        prod_d = tbl[{a_dig, b_dig}];
    end

    always_ff @(posedge clk) begin
        prod_q <= prod_d;
    end

    // R2: every registered digit product matches its two digits
    a_r2_lut_exact: assert property (@(posedge clk) disable iff (rst)
        prod_q == PW2'($past(a_dig)) * PW2'($past(b_dig)));

endmodule

// File: rtl/tree_level.sv
module tree_level #(
    parameter int NIN = 16,
    parameter int PW  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NIN-1:0][PW-1:0]      opnd,
    output logic [NIN/2-1:0][PW-1:0]    sum_q
);
    localparam int NOUT = NIN / 2;

    logic [NOUT-1:0][PW-1:0] sum_d;

    always_comb begin
        for (int k = 0; k < NOUT; k++) begin
            sum_d[k] = opnd[2*k] + opnd[2*k+1];
        end
    end

    always_ff @(posedge clk) begin
        sum_q <= sum_d;
    end

    for (genvar k = 0; k < NOUT; k++) begin : g_chk
        // R4: a node's sum never falls below either addend (no wrap-around)
        a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
            (sum_q[k] >= $past(opnd[2*k])) && (sum_q[k] >= $past(opnd[2*k+1])));
    end

endmodule

// File: rtl/mtree_mul.sv
module mtree_mul #(
    parameter int W = 8,
    parameter int D = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_vld,
    output logic [2*W-1:0] out_p
);
    localparam int ND  = W / D;
    localparam int NPP = ND * ND;
    localparam int LVL = $clog2(NPP);
    localparam int LAT = LVL + 1;
    localparam int PW  = 2 * W;

    typedef struct packed {
        logic [LAT-1:0] vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [2*D-1:0] dp [NPP];
    logic [NPP-1:0][PW-1:0] pp;

    // Digit grid: multiplicand digit i times multiplier digit j
    for (genvar i = 0; i < ND; i++) begin : g_row
        for (genvar j = 0; j < ND; j++) begin : g_col
            digit_lut #(.D(D)) u_lut (
                .clk    (clk),
                .rst    (rst),
                .a_dig  (in_a[i*D +: D]),
                .b_dig  (in_b[j*D +: D]),
                .prod_q (dp[i*ND + j])
            );
            assign pp[i*ND + j] = PW'(dp[i*ND + j]) << (D * (i + j));
        end
    end

    // Registered binary adder tree
    for (genvar l = 0; l < LVL; l++) begin : g_lvl
        localparam int NIN = NPP >> l;
        logic [NIN/2-1:0][PW-1:0] sum;
        if (l == 0) begin : g_first
            tree_level #(.NIN(NIN), .PW(PW)) u_lvl (
                .clk(clk), .rst(rst), .opnd(pp), .sum_q(sum));
        end else begin : g_next
            tree_level #(.NIN(NIN), .PW(PW)) u_lvl (
                .clk(clk), .rst(rst), .opnd(g_lvl[l-1].sum), .sum_q(sum));
        end
    end

    assign out_p = g_lvl[LVL-1].sum[0];

    // Valid pipeline, same depth as the data path
    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = {ctl_q.vld[LAT-2:0], in_vld};
        if (rst) ctl_d.vld = '0;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign out_vld = ctl_q.vld[LAT-1];

    // Edges since reset, saturating at LAT; gives assertions a clean window
    logic [$clog2(LAT+1)-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst)                       since_q <= '0;
        else if (int'(since_q) < LAT)  since_q <= since_q + 1'b1;
    end

    // R1: end-to-end product matches the operands LAT edges earlier
    a_r1_product: assert property (@(posedge clk) disable iff (rst)
        (int'(since_q) == LAT && out_vld) |->
            out_p == PW'($past(in_a, LAT)) * PW'($past(in_b, LAT)));

    // R5: output valid is the input valid delayed by LAT edges
    a_r5_vld_latency: assert property (@(posedge clk) disable iff (rst)
        (int'(since_q) == LAT) |-> out_vld == $past(in_vld, LAT));

    // R8: a reset edge leaves no valid product behind it
    a_r8_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> !out_vld);

endmodule

// File: tb/mtree_mul_tb_top.sv
module mtree_mul_tb_top;
    localparam int W   = 8;
    localparam int D   = 2;
    localparam int LAT = 1 + 2 * $clog2(W / D);
    localparam int HN  = 1024;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_vld = 1'b0;
    logic [W-1:0]   in_a = '0;
    logic [W-1:0]   in_b = '0;
    logic           out_vld;
    logic [2*W-1:0] out_p;

    always #5ns clk = ~clk;

    mtree_mul #(.W(W), .D(D)) dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .out_vld(out_vld), .out_p(out_p));

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 0;
    bit             h_v   [HN];
    logic [2*W-1:0] h_p   [HN];
    string          h_tag [HN];

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] acc;
        acc = '0;
        for (int k = 0; k < W; k++) begin
            if (b[k]) acc = acc + ({{W{1'b0}}, a} << k);
        end
        return acc;
    endfunction

    task automatic check_out();
        int  idx;
        bit  ev;
        idx = cyc - LAT;
        ev  = (idx >= 0) ? h_v[idx] : 1'b0;
        n_chk++;
        if (out_vld !== ev) begin
            n_bad++;
            $display("FAIL R5 R7 out_vld=%0d exp=%0d cycle %0d (case %s)",
                     out_vld, ev, cyc, (idx >= 0) ? h_tag[idx] : "R8");
        end
        if (ev) begin
            n_chk++;
            if (out_p !== h_p[idx]) begin
                n_bad++;
                $display("FAIL %s out_p=%0h exp=%0h cycle %0d", h_tag[idx], out_p, h_p[idx], cyc);
            end
        end
    endtask

    // One clock: check outputs, then drive the pair captured at the next edge
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit v, input bit r, input string tag);
        @(negedge clk);
        if (cyc > 0) check_out();
        in_a = a; in_b = b; in_vld = v; rst = r;
        h_v[cyc]   = v && !r;
        h_p[cyc]   = ref_mul(a, b);
        h_tag[cyc] = tag;
        if (r) begin
            for (int k = 0; k < LAT; k++) begin
                if (cyc - k >= 0) h_v[cyc - k] = 1'b0;
            end
        end
        cyc++;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        void'($urandom(32'h5eed_2024));
        // R8: reset state, valid held low
        for (int k = 0; k < 4; k++) step('0, '0, 1'b1, 1'b1, "R8");
        // R1: zero and maximum operands
        step(8'h00, 8'h00, 1'b1, 1'b0, "R1");
        step(8'h00, 8'hFF, 1'b1, 1'b0, "R1");
        step(8'hFF, 8'h00, 1'b1, 1'b0, "R1");
        step(8'hFF, 8'hFF, 1'b1, 1'b0, "R1");
        step(8'h01, 8'h01, 1'b1, 1'b0, "R1");
        // R2: every digit combination at the lowest digit pair
        for (int x = 0; x < 4; x++)
            for (int y = 0; y < 4; y++)
                step(8'(x), 8'(y), 1'b1, 1'b0, "R2");
        // R3: one digit position excited in each operand
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                step(8'(3 << (2*i)), 8'(3 << (2*j)), 1'b1, 1'b0, "R3");
        // R4: carry-heavy patterns
        step(8'hFF, 8'hFF, 1'b1, 1'b0, "R4");
        step(8'hAA, 8'hFF, 1'b1, 1'b0, "R4");
        step(8'hFF, 8'h55, 1'b1, 1'b0, "R4");
        step(8'hFE, 8'hFD, 1'b1, 1'b0, "R4");
        // R7: bubbles between valid pairs
        for (int k = 0; k < 12; k++)
            step(8'($urandom), 8'($urandom), k % 2 == 0, 1'b0, "R7");
        // R8: reset while the pipeline is full, then resume at once
        for (int k = 0; k < 6; k++) step(8'($urandom), 8'($urandom), 1'b1, 1'b0, "R8");
        step(8'h77, 8'h99, 1'b1, 1'b1, "R8");
        for (int k = 0; k < 6; k++) step(8'($urandom), 8'($urandom), 1'b1, 1'b0, "R8");
        // R6: long back-to-back random stream
        for (int k = 0; k < 200; k++) step(8'($urandom), 8'($urandom), 1'b1, 1'b0, "R6");
        // R5: drain; the last product must arrive exactly LAT edges later
        for (int k = 0; k < LAT + 3; k++) step('0, '0, 1'b0, 1'b0, "R5");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule